// File: doc/BRIEF.md
# Comparator Output Change Interrupt Flag

This block watches the digital outputs of a pair of analog comparators and raises a sticky interrupt flag whenever either output no longer matches a reference copy. The reference copy is reloaded from the live outputs each time software reads or writes the comparator control register. That access is the only way to end a mismatch. Until it happens, the mismatch keeps setting the flag again, even after software clears it.

Software can also write the flag directly. Writing 0 clears it. Writing 1 sets it, which produces an interrupt without any comparator activity. The flag is always recorded. The interrupt request is forwarded only when three enables are all set: a local enable, a peripheral-group enable and a global enable. During sleep, a flagged and locally enabled event raises a wake request.

The comparator outputs are asynchronous to the clock. They pass through a synchronizer before they are compared.

Top module: `cmpchg_irq`

## Requirements
- R1: The live comparator bits pass through a two-flop synchronizer, and the flag sets when any synchronized bit differs from the stored copy. A change driven before rising edge k shows on `flag` after edge k+2.
- R2: A one-cycle pulse on `ctl_rd` or on `ctl_wr` loads the stored copy from the synchronized outputs. This ends the mismatch, so a flag cleared afterwards stays clear.
- R3: While a mismatch persists, a flag write of 0 clears `flag` for one cycle only, and the flag sets again on the following edge.
- R4: A flag write (`flag_wr`=1) loads `flag_wdata` into the flag on the next edge. A value of 1 sets the flag when no mismatch exists, and in that cycle the write overrides any mismatch-driven set.
- R5: The flag sets whatever the enables are. `irq` is a register equal to the previous cycle's flag ANDed with `en_local`, `en_periph` and `en_global`.
- R6: `wake` is a register equal to the previous cycle's flag ANDed with `sleep`, `en_local` and `en_periph`; `en_global` is not needed. The flag and the stored copy keep working during sleep.
- R7: On an edge where `ctl_rd` or `ctl_wr` is high, a mismatch does not set the flag. An output change that first becomes visible in that cycle is absorbed into the copy and never flagged.
- R8: A synchronous active-high `rst` clears the synchronizer, the stored copy, `flag`, `irq` and `wake` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_live | input | NUM_CMP | Live comparator output bits (asynchronous) |
| ctl_rd | input | 1 | Control register read strobe |
| ctl_wr | input | 1 | Control register write strobe |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Value written into the flag |
| en_local | input | 1 | Local interrupt enable |
| en_periph | input | 1 | Peripheral-group interrupt enable |
| en_global | input | 1 | Global interrupt enable |
| sleep | input | 1 | Device is in sleep |
| flag | output | 1 | Sticky change flag |
| irq | output | 1 | Registered, fully gated interrupt request |
| wake | output | 1 | Registered wake-from-sleep request |

## Verification
The assertions assume that the strobes are clean single-clock-domain signals that are either 0 or 1 at every edge. They also assume that `cmp_live` changes slowly enough for each new level to reach the synchronizer's output stage. The bench drives every input on the falling clock edge and holds each comparator level for at least three cycles, so both assumptions hold. The lost-event case is set up by timing a read strobe to land on the exact edge where the new level first leaves the synchronizer.

// File: rtl/cmpchg_pkg.sv
package cmpchg_pkg;
  localparam int CMP_COUNT_DEF  = 2;
  localparam int SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic loc;
    logic grp;
    logic glb;
  } irq_gate_t;
endpackage

// File: rtl/cmpchg_sync.sv
module cmpchg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/cmpchg_detect.sv
module cmpchg_detect #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  input  logic             access,
  output logic [WIDTH-1:0] snap,
  output logic             differ
);
  always_ff @(posedge clk) begin
    if (rst)         snap <= '0;
    else if (access) snap <= cur;
  end

  assign differ = |(cur ^ snap);
endmodule

// File: rtl/cmpchg_flag.sv
module cmpchg_flag
  import cmpchg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      differ,
  input  logic      access,
  input  logic      sw_wr,
  input  logic      sw_val,
  input  irq_gate_t gate,
  input  logic      sleep,
  output logic      flag_q,
  output logic      irq_q,
  output logic      wake_q
);
  logic set_evt;

  // An access wins over a mismatch-driven set in the same cycle.
  assign set_evt = differ && !access;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (sw_wr)        flag_q <= sw_val;
      else if (set_evt) flag_q <= 1'b1;
      irq_q  <= flag_q && gate.loc && gate.grp && gate.glb;
      wake_q <= flag_q && sleep && gate.loc && gate.grp;
    end
  end
endmodule

// File: rtl/cmpchg_irq.sv
module cmpchg_irq
  import cmpchg_pkg::*;
#(
  parameter int NUM_CMP    = CMP_COUNT_DEF,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CMP-1:0] cmp_live,
  input  logic               ctl_rd,
  input  logic               ctl_wr,
  input  logic               flag_wr,
  input  logic               flag_wdata,
  input  logic               en_local,
  input  logic               en_periph,
  input  logic               en_global,
  input  logic               sleep,
  output logic               flag,
  output logic               irq,
  output logic               wake
);
  logic [NUM_CMP-1:0] cmp_sync;
  logic [NUM_CMP-1:0] cmp_snap;
  logic               reg_access;
  logic               mismatch;
  irq_gate_t          gate;

  assign reg_access = ctl_rd || ctl_wr;
  assign gate       = '{loc: en_local, grp: en_periph, glb: en_global};

  cmpchg_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cmp_live),
    .d_sync  (cmp_sync)
  );

  cmpchg_detect #(.WIDTH(NUM_CMP)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .cur    (cmp_sync),
    .access (reg_access),
    .snap   (cmp_snap),
    .differ (mismatch)
  );

  cmpchg_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .differ (mismatch),
    .access (reg_access),
    .sw_wr  (flag_wr),
    .sw_val (flag_wdata),
    .gate   (gate),
    .sleep  (sleep),
    .flag_q (flag),
    .irq_q  (irq),
    .wake_q (wake)
  );
endmodule

// File: rtl/cmpchg_irq_chk.sv
module cmpchg_irq_chk #(
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               ctl_rd,
  input logic               ctl_wr,
  input logic               flag_wr,
  input logic               flag_wdata,
  input logic               en_local,
  input logic               en_periph,
  input logic               en_global,
  input logic               sleep,
  input logic               flag,
  input logic               irq,
  input logic               wake,
  input logic [NUM_CMP-1:0] synced,
  input logic [NUM_CMP-1:0] copy
);
  // R1
  mismatch_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr && !ctl_rd && !ctl_wr && (synced != copy)) |=> flag);

  // R2
  copy_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd || ctl_wr) |=> (copy == $past(synced)));

  // R4
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (flag == $past(flag_wdata)));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(flag && en_local && en_periph && en_global)));

  // R6
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake == $past(flag && sleep && en_local && en_periph)));

  // R7
  access_blocks_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((ctl_rd || ctl_wr) && !flag_wr && !flag) |=> !flag);

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!flag && !irq && !wake && (copy == '0)));
endmodule

bind cmpchg_irq cmpchg_irq_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_rd     (ctl_rd),
  .ctl_wr     (ctl_wr),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .en_local   (en_local),
  .en_periph  (en_periph),
  .en_global  (en_global),
  .sleep      (sleep),
  .flag       (flag),
  .irq        (irq),
  .wake       (wake),
  .synced     (cmp_sync),
  .copy       (cmp_snap)
);

// File: tb/tb_cmpchg_irq.sv
module tb_cmpchg_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmp_live = '0;
  logic       ctl_rd = 0, ctl_wr = 0, flag_wr = 0, flag_wdata = 0;
  logic       en_local = 0, en_periph = 0, en_global = 0, sleep = 0;
  logic       flag, irq, wake;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpchg_irq dut (
    .clk(clk), .rst(rst), .cmp_live(cmp_live),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .en_local(en_local), .en_periph(en_periph), .en_global(en_global),
    .sleep(sleep), .flag(flag), .irq(irq), .wake(wake)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic resync();
    tick(3);
    ctl_rd = 1; flag_wr = 1; flag_wdata = 0;
    tick(1);
    ctl_rd = 0; flag_wr = 0;
    tick(2);
    check("R2", "flag after resync", flag, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1; tick(3); rst = 0; tick(1);
    check("R8", "flag at reset", flag, 1'b0);
    check("R8", "irq at reset", irq, 1'b0);
    check("R8", "wake at reset", wake, 1'b0);
  endtask

  task automatic t_change_latency();
    cmp_live = 2'b01;
    tick(2);
    check("R1", "flag before sync done", flag, 1'b0);
    tick(1);
    check("R1", "flag after sync", flag, 1'b1);
    resync();
  endtask

  task automatic t_persist_and_reload();
    cmp_live = 2'b11;
    tick(3);
    check("R1", "flag on bit1 change", flag, 1'b1);
    flag_wr = 1; flag_wdata = 0; tick(1); flag_wr = 0;
    check("R3", "flag right after clear", flag, 1'b0);
    tick(1);
    check("R3", "flag resets on mismatch", flag, 1'b1);
    ctl_wr = 1; tick(1); ctl_wr = 0;
    check("R2", "access keeps flag", flag, 1'b1);
    flag_wr = 1; flag_wdata = 0; tick(1); flag_wr = 0;
    check("R2", "flag cleared", flag, 1'b0);
    tick(3);
    check("R2", "clear holds after reload", flag, 1'b0);
  endtask

  task automatic t_sw_set_and_gate();
    flag_wr = 1; flag_wdata = 1; tick(1); flag_wr = 0;
    check("R4", "software set", flag, 1'b1);
    tick(1);
    check("R5", "irq with enables off", irq, 1'b0);
    en_local = 1; en_periph = 1; tick(2);
    check("R5", "irq without global", irq, 1'b0);
    en_global = 1; tick(1);
    check("R5", "irq all enables", irq, 1'b1);
    flag_wr = 1; flag_wdata = 0; tick(1); flag_wr = 0;
    check("R4", "software clear", flag, 1'b0);
    tick(1);
    check("R5", "irq follows cleared flag", irq, 1'b0);
    en_local = 0; en_periph = 0; en_global = 0;
  endtask

  task automatic t_sleep_wake();
    sleep = 1; en_local = 1; en_periph = 1;
    cmp_live = 2'b10;
    tick(3);
    check("R6", "flag sets in sleep", flag, 1'b1);
    tick(1);
    check("R6", "wake raised", wake, 1'b1);
    check("R5", "irq gated by global", irq, 1'b0);
    en_local = 0; tick(1);
    check("R6", "wake needs local enable", wake, 1'b0);
    sleep = 0; en_periph = 0;
    resync();
  endtask

  task automatic t_lost_event();
    cmp_live = 2'b00;
    tick(2);
    ctl_rd = 1; tick(1); ctl_rd = 0;
    check("R7", "flag on colliding read", flag, 1'b0);
    tick(3);
    check("R7", "change absorbed into copy", flag, 1'b0);
  endtask

  task automatic t_reset_midway();
    flag_wr = 1; flag_wdata = 1; tick(1); flag_wr = 0;
    en_local = 1; en_periph = 1; en_global = 1; tick(1);
    check("R5", "irq before reset", irq, 1'b1);
    rst = 1; tick(1);
    check("R8", "flag cleared by reset", flag, 1'b0);
    check("R8", "irq cleared by reset", irq, 1'b0);
    rst = 0; en_local = 0; en_periph = 0; en_global = 0;
    tick(2);
  endtask

  initial begin
    t_reset();
    t_change_latency();
    t_persist_and_reload();
    t_sw_set_and_gate();
    t_sleep_wake();
    t_lost_event();
    t_reset_midway();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule